// File: doc/BRIEF.md
# Filtered Serial Command Receiver for a Display Controller

This block is the host-facing serial front end of a fluorescent-display controller. An external master frames each transfer with an active-low chip select and supplies its own serial clock. Both the serial clock and the serial data input are cleaned by a sampler running at half the system clock rate. A level is accepted only when two consecutive samples agree, so short spikes never reach the shift logic. Bytes are shifted in least significant bit first.

The first byte of every frame is a command. Three of the command kinds set display state, the digit scan start or a four-bit half of an eight-bit output port, and each is one byte long. The fourth kind configures the digit count and segment width. After it, the rest of the frame is display data, written into an internal display RAM from the highest active digit down to digit 0. Each digit takes two or three bytes, depending on the segment width. On the same frames the block shifts out two padding bytes and then six converter result bytes on its serial output. The output enable is off whenever chip select is high.

The display RAM has a registered read port for the scanning logic that sits outside the block.

Top module: `vfd_cmd_rx`

## Requirements
- R1: A change on `sclk` or `sdi` takes effect only when two consecutive samples, taken every `SMP_DIV` (2) system clocks, agree. A pulse lasting one system clock is ignored.
- R2: When `cs_n` goes high, the bit and byte position is discarded. The first byte of the next frame is always decoded as a command, even if the previous frame stopped partway through a byte.
- R3: Serial bytes are received and sent bit 0 first. The received bit is taken at the rising edge of the filtered serial clock.
- R4: A command with bits [7:6] = 00 is a port write. Bits [3:0] go to `port_out[3:0]` when bit 4 is 0, or to `port_out[7:4]` when bit 4 is 1. The other half of the port is unchanged.
- R5: Bits [7:6] = 10 is a display-state command: bit 0 sets `disp_on` and bits [2:1] set `duty`. Bits [7:6] = 01 is a start command: bits [3:0] set `dig_start`.
- R6: Bits [7:6] = 11 is a setup command. Bits [1:0] set `dig_code`, and the digit count is 7 + code. Bits [3:2] set `seg_mode`. Every later byte in the frame is display data. Data byte i goes to row (digits − 1 − i / B) at position i mod B, and the RAM address is row·3 + position.
- R7: B = 3 when `seg_mode` bit 1 is set (17 or more segments). Otherwise B = 2. When `seg_mode` = 00 (8 or fewer segments), position 1 of each row is a dummy byte and is not written.
- R8: Extra bytes after a one-byte command change nothing. Data bytes that arrive after digit 0 has been filled change nothing.
- R9: On `sdo`, byte index 2 to 7 of a frame carries `adc_data` channel 0 to 5 (channel n is bits [8n+7:8n]). Each bit is updated after a falling edge of the filtered serial clock and is stable at the next rising edge.
- R10: `sdo_en` is high within 3 system clocks after `cs_n` goes low. It is low whenever `cs_n` has been high for the last 3 system clocks.
- R11: After reset, `sdo_en`, `port_out`, `disp_on`, `duty`, `dig_start`, `seg_mode` and `dig_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the master, idle high |
| sdi | input | 1 | Serial data from the master |
| adc_data | input | 48 | Six converter result bytes, channel 0 in bits [7:0] |
| rd_addr | input | 5 | Display RAM read address (row·3 + position) |
| rd_data | output | 8 | Display RAM read data, one clock after the address |
| sdo | output | 1 | Serial data to the master |
| sdo_en | output | 1 | Drive enable for `sdo` |
| disp_on | output | 1 | Display enable setting |
| duty | output | 2 | Dimming duty code |
| dig_start | output | 4 | Digit start selection code |
| seg_mode | output | 2 | Segment width code |
| dig_code | output | 2 | Digit count code (count = 7 + code) |
| port_out | output | 8 | General output port value |

## Verification
The assertions assume that `sclk` and `sdi` hold each level much longer than the two-sample filter window, apart from deliberate single-clock spikes. They also assume that `cs_n` is high during and right after reset, so the frame logic starts idle. The bench holds each serial clock phase for 12 system clocks and changes `sdi` only in the low phase. It keeps chip select high before and after every frame, and it injects only single-clock spikes when it tests the filter.

// File: rtl/vfd_rx_pkg.sv
package vfd_rx_pkg;
  typedef enum logic [1:0] {
    CMD_PORT  = 2'b00,
    CMD_START = 2'b01,
    CMD_STATE = 2'b10,
    CMD_SETUP = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    SEG_NARROW = 2'b00,
    SEG_MID    = 2'b01,
    SEG_WIDE   = 2'b10,
    SEG_WIDE_X = 2'b11
  } seg_e;
endpackage

// File: rtl/vfd_glitch_filter.sv
module vfd_glitch_filter #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  logic smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp  <= RST_VAL;
      filt <= RST_VAL;
    end else if (tick) begin
      smp <= raw;
      if (raw == smp) filt <= raw;
    end
  end

  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && (raw != smp)) |=> $stable(filt)); // R1
endmodule

// File: rtl/vfd_ser_link.sv
module vfd_ser_link #(
  parameter int DW    = 8,
  parameter int NCH   = 6,
  parameter int PAD   = 2,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  logic               sclk_f,
  input  logic               sdi_f,
  input  logic [NCH*DW-1:0]  adc_data,
  output logic               byte_done,
  output logic [DW-1:0]      rx_byte,
  output logic [CNT_W-1:0]   byte_idx,
  output logic               sdo
);
  localparam int BW = $clog2(DW);
  localparam logic [CNT_W-1:0] PAD_C  = CNT_W'(PAD);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PAD + NCH);
  localparam logic [CNT_W-1:0] MAX_C  = '1;

  logic          sclk_d;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bit_cnt;
  logic [CNT_W-1:0] byte_cnt, ch;
  logic [DW-1:0] tx_byte;
  logic          rise, fall;

  assign rise = sclk_f & ~sclk_d;
  assign fall = ~sclk_f & sclk_d;
  assign ch   = byte_cnt - PAD_C;

  always_comb begin
    tx_byte = '1;
    if (byte_cnt >= PAD_C && byte_cnt < LAST_C) tx_byte = adc_data[ch*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      byte_idx  <= '0;
      sdo       <= 1'b1;
    end else begin
      sclk_d    <= sclk_f;
      byte_done <= 1'b0;
      if (!active) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (rise) begin
        shreg   <= {sdi_f, shreg[DW-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BW'(DW - 1)) begin
          byte_done <= 1'b1;
          rx_byte   <= {sdi_f, shreg[DW-1:1]};
          byte_idx  <= byte_cnt;
          if (byte_cnt != MAX_C) byte_cnt <= byte_cnt + 1'b1;
        end
      end else if (fall) begin
        sdo <= tx_byte[bit_cnt];
      end
    end
  end

  AST_NO_BYTE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |=> !byte_done); // R2
endmodule

// File: rtl/vfd_cmd_decode.sv
module vfd_cmd_decode
  import vfd_rx_pkg::*;
#(
  parameter int ROWS    = 10,
  parameter int BPR     = 3,
  parameter int MIN_DIG = 7,
  parameter int CNT_W   = 4,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  input  logic [CNT_W-1:0] byte_idx,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic             disp_on,
  output logic [1:0]       duty,
  output logic [3:0]       dig_start,
  output logic [1:0]       seg_mode,
  output logic [1:0]       dig_code,
  output logic [7:0]       port_out
);
  localparam int RW = $clog2(ROWS);
  localparam int PW = $clog2(BPR);

  logic          streaming, filled;
  logic [RW-1:0] row;
  logic [PW-1:0] pos, last_pos;
  logic          dummy;

  assign last_pos = seg_mode[1] ? PW'(BPR - 1) : PW'(1);
  assign dummy    = (seg_mode == SEG_NARROW) && (pos == PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      streaming <= 1'b0;
      filled    <= 1'b0;
      row       <= '0;
      pos       <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
      disp_on   <= 1'b0;
      duty      <= '0;
      dig_start <= '0;
      seg_mode  <= '0;
      dig_code  <= '0;
      port_out  <= '0;
    end else begin
      we <= 1'b0;
      if (byte_done) begin
        if (byte_idx == '0) begin
          streaming <= 1'b0;
          case (rx_byte[7:6])
            CMD_SETUP: begin
              seg_mode  <= rx_byte[3:2];
              dig_code  <= rx_byte[1:0];
              streaming <= 1'b1;
              filled    <= 1'b0;
              row       <= RW'(MIN_DIG - 1) + RW'(rx_byte[1:0]);
              pos       <= '0;
            end
            CMD_STATE: begin
              disp_on <= rx_byte[0];
              duty    <= rx_byte[2:1];
            end
            CMD_START: dig_start <= rx_byte[3:0];
            default: begin
              if (rx_byte[4]) port_out[7:4] <= rx_byte[3:0];
              else            port_out[3:0] <= rx_byte[3:0];
            end
          endcase
        end else if (streaming && !filled) begin
          if (!dummy) begin
            we    <= 1'b1;
            waddr <= AW'(row) * AW'(BPR) + AW'(pos);
            wdata <= rx_byte;
          end
          if (pos == last_pos) begin
            pos <= '0;
            if (row == '0) filled <= 1'b1;
            else           row    <= row - 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(waddr) < ROWS * BPR)); // R6
  AST_WRITE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(byte_done)); // R6
  AST_NARROW_SKIP: assert property (@(posedge clk) disable iff (rst)
    (we && seg_mode == SEG_NARROW) |-> ((32'(waddr) % BPR) == 0)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !byte_done |=> ($stable(port_out) && $stable(disp_on) && $stable(dig_start))); // R4
endmodule

// File: rtl/vfd_disp_ram.sv
module vfd_disp_ram #(
  parameter int DEPTH = 30,
  parameter int AW    = 5,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx #(
  parameter int SMP_DIV = 2,
  parameter int ROWS    = 10,
  parameter int BPR     = 3,
  parameter int NCH     = 6,
  parameter int PAD     = 2,
  parameter int MIN_DIG = 7,
  parameter int CNT_W   = 4,
  parameter int DEPTH   = ROWS * BPR,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic [NCH*8-1:0] adc_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic            sdo,
  output logic            sdo_en,
  output logic            disp_on,
  output logic [1:0]      duty,
  output logic [3:0]      dig_start,
  output logic [1:0]      seg_mode,
  output logic [1:0]      dig_code,
  output logic [7:0]      port_out
);
  logic       tick;
  logic [1:0] cs_s;
  logic       active;
  logic       sclk_f, sdi_f;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic [CNT_W-1:0] byte_idx;
  logic       we;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  generate
    if (SMP_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DVW = $clog2(SMP_DIV);
      logic [DVW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else if (div_cnt == DVW'(SMP_DIV - 1)) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == DVW'(SMP_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s   <= 2'b11;
      sdo_en <= 1'b0;
    end else begin
      cs_s   <= {cs_s[0], cs_n};
      sdo_en <= ~cs_s[1];
    end
  end
  assign active = ~cs_s[1];

  vfd_glitch_filter #(.RST_VAL(1'b1)) u_flt_clk (
    .clk(clk), .rst(rst), .tick(tick), .raw(sclk), .filt(sclk_f));
  vfd_glitch_filter #(.RST_VAL(1'b0)) u_flt_dat (
    .clk(clk), .rst(rst), .tick(tick), .raw(sdi), .filt(sdi_f));

  vfd_ser_link #(.DW(8), .NCH(NCH), .PAD(PAD), .CNT_W(CNT_W)) u_link (
    .clk(clk), .rst(rst), .active(active), .sclk_f(sclk_f), .sdi_f(sdi_f),
    .adc_data(adc_data), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_idx(byte_idx), .sdo(sdo));

  vfd_cmd_decode #(.ROWS(ROWS), .BPR(BPR), .MIN_DIG(MIN_DIG), .CNT_W(CNT_W), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
    .we(we), .waddr(waddr), .wdata(wdata), .disp_on(disp_on), .duty(duty),
    .dig_start(dig_start), .seg_mode(seg_mode), .dig_code(dig_code), .port_out(port_out));

  vfd_disp_ram #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(rd_addr), .rdata(rd_data));

  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en); // R10
endmodule

// File: tb/tb_vfd_cmd_rx.sv
module tb_vfd_cmd_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [47:0] adc_data = {8'h6E, 8'h19, 8'hD4, 8'h87, 8'h3C, 8'hA5};
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data, port_out;
  logic sdo, sdo_en, disp_on;
  logic [1:0] duty, seg_mode, dig_code;
  logic [3:0] dig_start;

  int checks = 0;
  int errors = 0;
  bit glitch = 1'b0;
  logic [7:0] txq   [0:39];
  logic [7:0] rxq   [0:39];
  logic [7:0] model [0:29];

  always #2 clk = ~clk;

  vfd_cmd_rx dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .adc_data(adc_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sdo(sdo), .sdo_en(sdo_en), .disp_on(disp_on),
    .duty(duty), .dig_start(dig_start), .seg_mode(seg_mode), .dig_code(dig_code),
    .port_out(port_out));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic s);
    @(negedge clk);
    sclk = 1'b0;
    sdi  = b;
    if (glitch) begin
      idle(4);
      sclk = 1'b1; sdi = ~b;
      idle(1);
      sclk = 1'b0; sdi = b;
      idle(7);
    end else begin
      idle(12);
    end
    s = sdo;
    sclk = 1'b1;
    idle(12);
  endtask

  task automatic send_frame(input int n);
    logic s;
    @(negedge clk);
    cs_n = 1'b0;
    idle(8);
    chk("R10 enable in frame", 32'(sdo_en), 32'd1);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        send_bit(txq[k][b], s);
        rxq[k][b] = s;
      end
    end
    idle(4);
    cs_n = 1'b1;
    idle(10);
    chk("R10 enable after frame", 32'(sdo_en), 32'd0);
  endtask

  task automatic model_stream(input int n);
    int row, pos, last;
    logic [1:0] mode;
    mode = txq[0][3:2];
    row  = 6 + int'(txq[0][1:0]);
    pos  = 0;
    last = mode[1] ? 2 : 1;
    for (int i = 1; i < n; i++) begin
      if (row >= 0) begin
        if (!(mode == 2'b00 && pos == 1)) model[row*3 + pos] = txq[i];
        if (pos == last) begin pos = 0; row--; end
        else pos++;
      end
    end
  endtask

  task automatic check_ram(input string tag);
    for (int a = 0; a < 30; a++) begin
      @(negedge clk);
      rd_addr = 5'(a);
      @(negedge clk);
      chk(tag, {24'd0, rd_data}, {24'd0, model[a]});
    end
  endtask

  task automatic t_reset;
    chk("R11 sdo_en", 32'(sdo_en), 32'd0);
    chk("R11 port_out", 32'(port_out), 32'd0);
    chk("R11 disp_on", 32'(disp_on), 32'd0);
    chk("R11 duty", 32'(duty), 32'd0);
    chk("R11 dig_start", 32'(dig_start), 32'd0);
    chk("R11 seg_mode/dig_code", {28'd0, seg_mode, dig_code}, 32'd0);
  endtask

  task automatic t_port;
    txq[0] = 8'b0001_1010;
    send_frame(1);
    chk("R4 R3 upper nibble", 32'(port_out), 32'hA0);
    txq[0] = 8'b0000_0101;
    txq[1] = 8'h00;
    txq[2] = 8'b0001_1111;
    send_frame(3);
    chk("R4 R8 lower nibble, extras ignored", 32'(port_out), 32'hA5);
  endtask

  task automatic t_state_start;
    txq[0] = 8'b1000_0111;
    send_frame(1);
    chk("R5 disp_on", 32'(disp_on), 32'd1);
    chk("R5 duty", 32'(duty), 32'd3);
    txq[0] = 8'b0100_1001;
    send_frame(1);
    chk("R5 dig_start", 32'(dig_start), 32'd9);
    chk("R5 other settings kept", 32'(port_out), 32'hA5);
  endtask

  task automatic t_wide;
    txq[0] = 8'b1100_1011;
    for (int i = 1; i <= 30; i++) txq[i] = 8'(i * 37 + 11);
    txq[31] = 8'hEE;
    send_frame(32);
    model_stream(32);
    chk("R6 seg_mode", 32'(seg_mode), 32'd2);
    chk("R6 dig_code", 32'(dig_code), 32'd3);
    check_ram("R6 R7 R8 wide layout");
    for (int c = 0; c < 6; c++)
      chk("R9 R3 converter byte", 32'(rxq[2 + c]), 32'(adc_data[c*8 +: 8]));
  endtask

  task automatic t_mid;
    txq[0] = 8'b1100_0100;
    for (int i = 1; i <= 14; i++) txq[i] = 8'(i * 53 + 5);
    send_frame(15);
    model_stream(15);
    check_ram("R7 two-byte layout");
  endtask

  task automatic t_narrow;
    txq[0] = 8'b1100_0001;
    for (int i = 1; i <= 16; i++) txq[i] = 8'(i * 29 + 200);
    txq[17] = 8'h55;
    send_frame(18);
    model_stream(18);
    check_ram("R7 R8 dummy byte skipped");
  endtask

  task automatic t_glitch;
    glitch = 1'b1;
    txq[0] = 8'b0001_0110;
    send_frame(1);
    glitch = 1'b0;
    chk("R1 spikes filtered", 32'(port_out), 32'h65);
  endtask

  task automatic t_partial;
    logic s;
    @(negedge clk);
    cs_n = 1'b0;
    idle(8);
    for (int b = 0; b < 4; b++) send_bit(1'b1, s);
    idle(4);
    cs_n = 1'b1;
    idle(10);
    chk("R2 partial byte no effect", 32'(port_out), 32'h65);
    txq[0] = 8'b0000_0011;
    send_frame(1);
    chk("R2 realigned command", 32'(port_out), 32'h63);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(6);
    rst = 1'b0;
    idle(4);
    t_reset();
    t_port();
    t_state_start();
    t_wide();
    t_mid();
    t_narrow();
    t_glitch();
    t_partial();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule